// File: doc/BRIEF.md
# Nonvolatile memory store sequencer

This block fronts a byte-wide static array that has a shadow nonvolatile copy. A host reaches the array through an asynchronous-style bus made of active-low chip enable, write enable and output enable, a 15-bit address and a bidirectional 8-bit data bus. All bus pins are sampled on the rising clock edge, and read data appears on the data bus one clock after the read is sampled.

Two events copy the working array into the shadow array. The first is a software command: six read accesses to a fixed list of addresses, in a fixed order. The second is a hardware request on an active-low strobe that has been held low long enough. While a copy runs, the block raises `busy`, floats the data bus and drops host writes, all for a set number of clocks. When reset is released, the block first copies the shadow array back into the working array, with the same lockout, and only then serves the host. Both arrays are models. The working array keeps `2**ARR_AW` bytes, indexed by the low address bits.

Top module: `nvs_store_seq`

## Requirements
- R1: With `ce_n` low, `we_n` high and `oe_n` low at a clock edge, the byte at that address is driven on `dq` after that edge. With `ce_n` low and `we_n` low, `dq` is written into that address. With `ce_n` high, `dq` is left undriven.
- R2: Array locations are selected by `addr[ARR_AW-1:0]`. Addresses that differ only in the upper bits reach the same byte.
- R3: Six read accesses to 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x03F8, in that order, start a store. `busy` is high after the clock edge that samples the sixth read. A read access is a sampled read whose address differs from the previous cycle, or that follows a cycle with no read.
- R4: A store keeps `busy` high for `STORE_CYC` clocks. Afterwards the shadow array holds the working-array contents from the moment the store began.
- R5: A write, or a read access that does not match the next expected address, returns the command detector to its start. A read access to 0x0E38 that breaks the order counts as step one of a new attempt.
- R6: `hs_n` passes through a two-flop synchronizer. It is accepted as a request only after it is sampled low for `HS_MIN` consecutive clocks. A shorter low pulse has no effect.
- R7: After an accepted hardware request, the host keeps access for `HS_DELAY` clocks. `busy` first reads high `2 + HS_MIN + HS_DELAY` clock edges after `hs_n` falls.
- R8: `busy` is high during reset. After reset is released, a recall keeps `busy` high for `RECALL_CYC` clocks and leaves the working array equal to the shadow array. Reset does not clear the shadow array.
- R9: While `busy` is high, reads leave `dq` undriven, writes are dropped and the command detector is held at its start.
- R10: A hardware request made while a store runs is dropped. It does not cause a second store when the first one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release starts the recall |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address |
| dq | inout | 8 | Data bus, driven by the block on reads |
| hs_n | input | 1 | Hardware store strobe, active low |
| busy | output | 1 | High during store or recall |

## Verification
The assertions assume that the bus pins and `hs_n` are stable around the sampling edge. They also assume that `STORE_CYC` and `RECALL_CYC` are at least the array depth, and that `HS_DELAY` is at least one. The bench changes inputs only on falling edges and separates bus accesses with an idle cycle, so every read is a fresh access. It draws random data and upper address bits from a seeded `$urandom`. The directed cases cover the command order, a broken order, a restart on the first address, short and valid strobes, and strobes that arrive during a store.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  localparam int ADDR_W  = 15;
  localparam int DATA_W  = 8;
  localparam int SEQ_LEN = 6;

  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PEND   = 2'd2,
    ST_STORE  = 2'd3
  } nvs_state_e;

  // address expected at each step of the software command
  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [2:0] step);
    case (step)
      3'd0:    return 15'h0E38;
      3'd1:    return 15'h31C7;
      3'd2:    return 15'h03E0;
      3'd3:    return 15'h3C1F;
      3'd4:    return 15'h303F;
      default: return 15'h03F8;
    endcase
  endfunction

  // step after a read access; wraps to zero on completion
  function automatic logic [2:0] cmd_next(input logic [2:0] step,
                                          input logic [ADDR_W-1:0] a);
    if (a == cmd_addr(step))
      return (step == 3'(SEQ_LEN-1)) ? 3'd0 : step + 3'd1;
    else if (a == cmd_addr(3'd0))
      return 3'd1;
    else
      return 3'd0;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvs_cmd_det.sv
module nvs_cmd_det
  import nvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rd_now,
  input  logic              wr_now,
  input  logic [ADDR_W-1:0] addr,
  output logic              fire
);
  logic              rd_prev;
  logic [ADDR_W-1:0] addr_prev;
  logic [2:0]        step_q;
  logic              rd_evt;

  assign rd_evt = rd_now && (!rd_prev || (addr != addr_prev));
  assign fire   = rd_evt && !clr && (step_q == 3'(SEQ_LEN-1)) &&
                  (addr == cmd_addr(step_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev   <= 1'b0;
      addr_prev <= '0;
      step_q    <= '0;
    end else begin
      rd_prev   <= rd_now;
      addr_prev <= addr;
      if (clr || wr_now)
        step_q <= '0;
      else if (rd_evt)
        step_q <= cmd_next(step_q, addr);
    end
  end

  a_r9_held_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (step_q == 3'd0));
  a_r5_write_resets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |=> (step_q == 3'd0));
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (step_q == 3'd0));
endmodule

// File: rtl/nvs_hs_filt.sv
module nvs_hs_filt #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_n,
  output logic req
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          s1, s2;
  logic [CW-1:0] low_cnt;

  assign req = !s2 && (low_cnt == CW'(MIN_LOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      low_cnt <= '0;
    end else begin
      s1 <= hs_n;
      s2 <= s1;
      if (s2)
        low_cnt <= '0;
      else if (low_cnt != CW'(MIN_LOW))
        low_cnt <= low_cnt + CW'(1);
    end
  end

  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  a_r6_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
    s2 |=> !req);
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW_ARR     = 10,
  parameter int STORE_CYC  = 1562500,
  parameter int RECALL_CYC = 2500000,
  parameter int HOLD_DLY   = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_fire,
  input  logic              hw_req,
  output logic              busy,
  output logic              copy_st,
  output logic              copy_rc,
  output logic [AW_ARR-1:0] idx
);
  localparam int DEPTH = 1 << AW_ARR;
  localparam int TMAX  = imax(imax(STORE_CYC, RECALL_CYC), imax(HOLD_DLY, DEPTH));
  localparam int TW    = $clog2(TMAX + 1);
  localparam logic [TW-1:0] ST_LAST = TW'(STORE_CYC - 1);
  localparam logic [TW-1:0] RC_LAST = TW'(RECALL_CYC - 1);
  localparam logic [TW-1:0] DL_LAST = TW'(HOLD_DLY - 1);
  localparam logic [TW-1:0] DEP     = TW'(DEPTH);

  nvs_state_e    state_q;
  logic [TW-1:0] tmr_q;
  logic          in_win;

  assign in_win  = tmr_q < DEP;
  assign busy    = (state_q == ST_RECALL) || (state_q == ST_STORE);
  assign copy_st = (state_q == ST_STORE) && in_win;
  assign copy_rc = (state_q == ST_RECALL) && in_win;
  assign idx     = tmr_q[AW_ARR-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RECALL;
      tmr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RECALL: begin
          if (tmr_q == RC_LAST) begin state_q <= ST_IDLE; tmr_q <= '0; end
          else tmr_q <= tmr_q + TW'(1);
        end
        ST_IDLE: begin
          if (sw_fire)     begin state_q <= ST_STORE; tmr_q <= '0; end
          else if (hw_req) begin state_q <= ST_PEND;  tmr_q <= '0; end
        end
        ST_PEND: begin
          if (tmr_q == DL_LAST) begin state_q <= ST_STORE; tmr_q <= '0; end
          else tmr_q <= tmr_q + TW'(1);
        end
        ST_STORE: begin
          if (tmr_q == ST_LAST) begin state_q <= ST_IDLE; tmr_q <= '0; end
          else tmr_q <= tmr_q + TW'(1);
        end
      endcase
    end
  end

  a_r4_store_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE && tmr_q != ST_LAST) |=> (state_q == ST_STORE));
  a_r7_pend_to_store: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PEND && tmr_q == DL_LAST) |=> (state_q == ST_STORE));
  a_r8_recall_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RECALL) |=> (state_q != ST_RECALL));
  a_r10_no_requeue: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STORE) |=> (state_q == ST_STORE || state_q == ST_IDLE));
endmodule

// File: rtl/nvs_store_seq.sv
module nvs_store_seq
  import nvs_pkg::*;
#(
  parameter int ARR_AW     = 10,
  parameter int STORE_CYC  = 1562500,
  parameter int RECALL_CYC = 2500000,
  parameter int HS_MIN     = 2,
  parameter int HS_DELAY   = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dq,
  input  logic              hs_n,
  output logic              busy
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  logic              rd_now, wr_now, host_wr;
  logic              sw_fire, hw_req;
  logic              copy_st, copy_rc;
  logic [ARR_AW-1:0] idx, lo;
  logic              drv_q;
  logic [DATA_W-1:0] rdata_q;

  assign rd_now  = !ce_n && we_n && !oe_n;
  assign wr_now  = !ce_n && !we_n;
  assign host_wr = wr_now && !busy;
  assign lo      = addr[ARR_AW-1:0];
  assign dq      = drv_q ? rdata_q : 'z;

  nvs_cmd_det u_det (
    .clk(clk), .rst_n(rst_n), .clr(busy), .rd_now(rd_now),
    .wr_now(wr_now), .addr(addr), .fire(sw_fire)
  );

  nvs_hs_filt #(.MIN_LOW(HS_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .hs_n(hs_n), .req(hw_req)
  );

  nvs_ctrl #(
    .AW_ARR(ARR_AW), .STORE_CYC(STORE_CYC),
    .RECALL_CYC(RECALL_CYC), .HOLD_DLY(HS_DELAY)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_fire(sw_fire), .hw_req(hw_req),
    .busy(busy), .copy_st(copy_st), .copy_rc(copy_rc), .idx(idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= rd_now && !busy;
  end

  always_ff @(posedge clk) begin
    if (copy_rc)      sram[idx] <= shadow[idx];
    else if (host_wr) sram[lo]  <= dq;
    if (copy_st)      shadow[idx] <= sram[idx];
    rdata_q <= sram[lo];
  end

  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !drv_q);
  a_r1_deselect_float: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !drv_q);
endmodule

// File: tb/test_nvs_store_seq.sv
module test_nvs_store_seq;
  localparam int AW = 6, DEPTH = 1 << AW;
  localparam int ST = 100, RC = 120, HMIN = 3, HDLY = 5;
  localparam logic [14:0] CMD [6] = '{15'h0E38, 15'h31C7, 15'h03E0,
                                      15'h3C1F, 15'h303F, 15'h03F8};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hs_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  tb_dq = '0;
  logic        tb_drv = 1'b0;
  logic        busy;
  wire  [7:0]  dq;
  int checks = 0, fails = 0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] shd_m [DEPTH];

  always #4 clk = ~clk;
  assign dq = tb_drv ? tb_dq : 'z;
  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (dq[g]);
  end

  nvs_store_seq #(.ARR_AW(AW), .STORE_CYC(ST), .RECALL_CYC(RC),
                  .HS_MIN(HMIN), .HS_DELAY(HDLY)) i_nvs_store_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq(dq), .hs_n(hs_n), .busy(busy));

  function automatic logic [14:0] alias_addr(input int i);
    return {9'($urandom), 6'(i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tb_drv = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
    @(posedge clk); #1 d = dq;
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a;
    tb_dq = d; tb_drv = 1'b1;
    @(posedge clk);
    @(negedge clk); idle();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk); #1;
      if (!busy) break;
      n++;
    end
  endtask

  task automatic do_reset(input string tag);
    int n;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b1, {tag, " R8 busy in reset"}, busy, 1);
    rst_n = 1'b1;
    wait_idle(n);
    chk(n == RC - 1, {tag, " R8 recall length"}, n, RC - 1);
  endtask

  task automatic send_cmd();
    logic [7:0] d;
    for (int i = 0; i < 6; i++) rd(CMD[i], d);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      rd(alias_addr(i), d);
      chk(d === mem_m[i], tag, d, mem_m[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    void'($urandom(32'd2024));
    do_reset("R8 power-up");

    // R1 / R2: random fill through aliased addresses, read back
    for (int i = 0; i < DEPTH; i++) begin
      mem_m[i] = 8'($urandom % 255);
      wr(alias_addr(i), mem_m[i]);
    end
    check_all("R2 alias readback");
    wr(15'd3, 8'h00); mem_m[3] = 8'h00;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; addr = 15'd3;
    @(posedge clk); #1;
    chk(dq === 8'hFF, "R1 deselected floats", dq, 8'hFF);
    @(negedge clk); idle();
    rd(15'd3, d);
    chk(d === 8'h00, "R1 read after write", d, 0);

    // R5: broken by a write
    rd(CMD[0], d); rd(CMD[1], d);
    wr(15'd7, 8'h11); mem_m[7] = 8'h11;
    for (int i = 2; i < 6; i++) rd(CMD[i], d);
    chk(busy === 1'b0, "R5 write breaks command", busy, 0);
    // R5: broken by a stray address
    rd(CMD[0], d); rd(CMD[1], d); rd(CMD[2], d); rd(15'h1234, d);
    for (int i = 3; i < 6; i++) rd(CMD[i], d);
    chk(busy === 1'b0, "R5 stray read breaks command", busy, 0);

    // R3 / R5 restart on first address, R4 length
    rd(CMD[0], d); rd(CMD[1], d);
    for (int i = 0; i < DEPTH; i++) shd_m[i] = mem_m[i];
    send_cmd();
    chk(busy === 1'b1, "R3 store after sixth read (with restart R5)", busy, 1);
    wait_idle(n);
    chk(n == ST - 1, "R4 store length", n, ST - 1);

    // R9 / R10: second store, access and strobe during it
    send_cmd();
    rd(15'd3, d);
    chk(d === 8'hFF, "R9 read floats while busy", d, 8'hFF);
    wr(15'd3, 8'h5A);
    @(negedge clk); hs_n = 1'b0;
    repeat (HMIN + 3) @(negedge clk);
    hs_n = 1'b1;
    wait_idle(n);
    n = 0;
    repeat (HDLY + HMIN + 20) begin
      @(posedge clk); #1;
      if (busy) n++;
    end
    chk(n == 0, "R10 strobe during store dropped", n, 0);
    rd(15'd3, d);
    chk(d === 8'h00, "R9 write while busy dropped", d, 0);

    // R4 / R8: scramble working array, recall restores first snapshot
    for (int i = 0; i < DEPTH; i++) begin
      mem_m[i] = 8'($urandom);
      wr(alias_addr(i), mem_m[i]);
    end
    do_reset("R8 second");
    for (int i = 0; i < DEPTH; i++) mem_m[i] = shd_m[i];
    check_all("R4 R8 shadow restored");

    // R6: short strobe ignored
    @(negedge clk); hs_n = 1'b0;
    repeat (HMIN - 1) @(negedge clk);
    hs_n = 1'b1;
    n = 0;
    repeat (HMIN + HDLY + 20) begin
      @(posedge clk); #1;
      if (busy) n++;
    end
    chk(n == 0, "R6 short strobe ignored", n, 0);

    // R6 / R7: valid strobe, exact latency, then snapshot
    for (int i = 0; i < DEPTH; i++) begin
      mem_m[i] = 8'($urandom);
      wr(alias_addr(i), mem_m[i]);
      shd_m[i] = mem_m[i];
    end
    @(negedge clk); hs_n = 1'b0;
    n = 0;
    while (n < 100) begin
      @(posedge clk); #1; n++;
      if (busy) break;
    end
    chk(n == 2 + HMIN + HDLY, "R7 R6 strobe to busy latency", n, 2 + HMIN + HDLY);
    @(negedge clk); hs_n = 1'b1;
    wait_idle(n);
    for (int i = 0; i < DEPTH; i++) wr(alias_addr(i), ~shd_m[i]);
    do_reset("R8 third");
    for (int i = 0; i < DEPTH; i++) mem_m[i] = shd_m[i];
    check_all("R4 hardware store snapshot");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule